// File: doc/BRIEF.md
# DRAM Auto-Refresh Scheduler with Postponement

This block paces auto-refresh for a DRAM controller whose logic runs at half the memory clock rate. An interval timer, programmed through one configuration word, adds a refresh to a pending count each time it expires. While refreshes are owed and no refresh recovery is running, the block raises a request. The command path answers with a grant in a cycle when it can give up the bus. Each grant issues one refresh and holds the busy flag for the recovery time.

Refreshes may be put off while traffic keeps the grant low. The pending count stops at a programmed cap, and at the cap the block raises an urgent stall that tells the command path to stop new work until a refresh gets through. Both timing fields are written as controller-clock counts less two. With a 5 ns controller clock, a 7.8 us refresh period is written as 1558 and a 127.5 ns refresh cycle time is written as 24. The usual cap is 7. Nothing runs until the initialization-done input is high.

Top module: `refresh_sched`

## Requirements
- R1: The configuration word is decoded as follows: bits [15:0] hold the interval field I, bits [23:16] hold the recovery field R, and bits [26:24] hold the cap field C. Bits [31:27] have no effect.
- R2: While init_done is high, the interval timer expires once every I+2 clock cycles, counting from the rising edge of init_done. Each expiry adds one to the pending count. With no refresh owed beforehand, ref_req rises on the (I+2)th cycle.
- R3: While init_done is low, ref_req, ref_urgent and ref_busy are low. In that state the pending count, the interval timer and the recovery timer are all held at zero.
- R4: ref_req is high exactly when init_done is high, the pending count is non-zero and no recovery is running. A cycle with both ref_req and ref_grant high issues one refresh, which takes one off the pending count.
- R5: After an issued refresh, ref_busy is high for exactly R+2 cycles, starting with the next cycle, and ref_req stays low throughout. When the grant is held high and refreshes are still owed, they are issued back to back, one every R+3 cycles.
- R6: The pending count saturates at the effective cap, which is C, or 1 when C is 0. Expiries that arrive at the cap are lost.
- R7: ref_urgent is high exactly when init_done is high and the pending count equals the effective cap.
- R8: A grant in a cycle when ref_req is low has no effect.
- R9: An active-low rst_n clears all state. Outputs are low during reset and right after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock (half memory rate) |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_done | input | 1 | DRAM initialization finished; enables scheduling |
| cfg | input | 32 | Configuration word: interval, recovery and cap fields |
| ref_grant | input | 1 | Command path yields the bus to the refresh request |
| ref_req | output | 1 | A refresh is owed and may be issued now |
| ref_urgent | output | 1 | Pending count at the cap; command path must stall |
| ref_busy | output | 1 | Refresh recovery in progress; no commands allowed |

## Verification
The grant is driven in several patterns, and each one separates different faults.
- A long low grant lets refreshes pile up, which shows whether the cap saturates and whether the urgent stall appears.
- A grant held high afterwards drains the backlog, which shows whether refreshes go out back to back with exactly the recovery gap between them.
- A grant that toggles in a fixed pattern, including grants during recovery, shows whether grants with no request pending are ignored.
- A grant during init-low shows that nothing is scheduled before initialization.

Three configurations are used:
- small fields;
- the realistic field values with the unused high bits set;
- a cap field of zero.

Together they test field decoding, the I+2 timer period and the rule that a cap of zero counts as one.

// File: rtl/refresh_pkg.sv
package refresh_pkg;
    localparam int CFG_W    = 32;
    localparam int INTV_W   = 16;
    localparam int RCV_W    = 8;
    localparam int CAP_W    = 3;
    localparam int INTV_LSB = 0;
    localparam int RCV_LSB  = 16;
    localparam int CAP_LSB  = 24;
    // fields hold controller-clock counts minus this bias
    localparam int HR_BIAS  = 2;

    typedef struct packed {
        logic [CAP_W-1:0]  cap;
        logic [RCV_W-1:0]  rcv;
        logic [INTV_W-1:0] intv;
    } ref_cfg_t;

    function automatic ref_cfg_t decode_cfg(input logic [CFG_W-1:0] raw);
        ref_cfg_t c;
        c.intv = raw[INTV_LSB +: INTV_W];
        c.rcv  = raw[RCV_LSB  +: RCV_W];
        c.cap  = raw[CAP_LSB  +: CAP_W];
        return c;
    endfunction
endpackage

// File: rtl/refresh_interval_timer.sv
module refresh_interval_timer #(
    parameter int W    = refresh_pkg::INTV_W,
    parameter int BIAS = refresh_pkg::HR_BIAS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] intv_field,
    output logic         tick
);
    localparam int CW = W + 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t st_d, st_q;
    logic [CW-1:0] last_cnt;

    always_comb begin
        st_d     = st_q;
        last_cnt = {1'b0, intv_field} + CW'(BIAS - 1);
        tick     = en && (st_q.cnt >= last_cnt);
        if (!en)
            st_d.cnt = '0;
        else if (tick)
            st_d.cnt = '0;
        else
            st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2: period is at least two cycles, so expiries never touch
    p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/refresh_pending_ctr.sv
module refresh_pending_ctr #(
    parameter int W = refresh_pkg::CAP_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         tick,
    input  logic         issue,
    input  logic [W-1:0] cap_field,
    output logic [W-1:0] pend,
    output logic         at_cap
);
    typedef struct packed {
        logic [W-1:0] pend;
    } pend_t;

    pend_t st_d, st_q;
    logic [W-1:0] cap_eff;
    logic [W:0]   sum;

    always_comb begin
        st_d    = st_q;
        cap_eff = (cap_field == '0) ? W'(1) : cap_field;
        sum     = {1'b0, st_q.pend} + {{W{1'b0}}, tick} - {{W{1'b0}}, issue};
        if (!en)
            st_d.pend = '0;
        else if (sum > {1'b0, cap_eff})
            st_d.pend = cap_eff;
        else
            st_d.pend = sum[W-1:0];
        pend   = st_q.pend;
        at_cap = (st_q.pend == cap_eff);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R6: never above the cap in force on the previous edge
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (st_q.pend <= $past(cap_eff)));
    // R4: an issue with no expiry removes exactly one
    p_issue_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && issue && !tick) |=> (st_q.pend == $past(st_q.pend) - 1'b1));
endmodule

// File: rtl/refresh_recovery_timer.sv
module refresh_recovery_timer #(
    parameter int W    = refresh_pkg::RCV_W,
    parameter int BIAS = refresh_pkg::HR_BIAS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         issue,
    input  logic [W-1:0] rcv_field,
    output logic         busy
);
    localparam int CW = W + 1;

    typedef struct packed {
        logic [CW-1:0] left;
    } rcv_t;

    rcv_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!en)
            st_d.left = '0;
        else if (issue)
            st_d.left = {1'b0, rcv_field} + CW'(BIAS);
        else if (st_q.left != '0)
            st_d.left = st_q.left - 1'b1;
        busy = (st_q.left != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R5: recovery starts on the cycle after a refresh goes out
    p_busy_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && issue) |=> busy);
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
    import refresh_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init_done,
    input  logic [CFG_W-1:0] cfg,
    input  logic             ref_grant,
    output logic             ref_req,
    output logic             ref_urgent,
    output logic             ref_busy
);
    ref_cfg_t         fields;
    logic             tick, issue, busy_int, at_cap;
    logic [CAP_W-1:0] pend;
    logic             unused_cfg_hi;

    assign fields        = decode_cfg(cfg);
    assign unused_cfg_hi = ^cfg[CFG_W-1:CAP_LSB+CAP_W];

    assign ref_req    = init_done && (pend != '0) && !busy_int;
    assign ref_urgent = init_done && at_cap;
    assign ref_busy   = init_done && busy_int;
    assign issue      = ref_req && ref_grant;

    refresh_interval_timer #(.W(INTV_W), .BIAS(HR_BIAS)) u_intv (
        .clk(clk), .rst_n(rst_n), .en(init_done),
        .intv_field(fields.intv), .tick(tick));

    refresh_pending_ctr #(.W(CAP_W)) u_pend (
        .clk(clk), .rst_n(rst_n), .en(init_done), .tick(tick),
        .issue(issue), .cap_field(fields.cap), .pend(pend), .at_cap(at_cap));

    refresh_recovery_timer #(.W(RCV_W), .BIAS(HR_BIAS)) u_rcv (
        .clk(clk), .rst_n(rst_n), .en(init_done), .issue(issue),
        .rcv_field(fields.rcv), .busy(busy_int));

    // R5: no request while recovery runs
    p_no_req_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ref_busy |-> !ref_req);
    // R3: silent before initialization
    p_init_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !init_done |-> !(ref_req || ref_busy || ref_urgent));
    // R7: an urgent stall always has a refresh owed or in flight
    p_urgent_owed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ref_urgent |-> (ref_req || ref_busy));
endmodule

// File: tb/tb_refresh_sched.sv
module tb_refresh_sched;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        init_done = 1'b0;
    logic [31:0] cfg = '0;
    logic        ref_grant = 1'b0;
    logic        ref_req, ref_urgent, ref_busy;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int issues[$];
    int m_intv = 0, m_pend = 0, m_busy = 0;

    always #5 clk = ~clk;

    refresh_sched dut (
        .clk(clk), .rst_n(rst_n), .init_done(init_done), .cfg(cfg),
        .ref_grant(ref_grant), .ref_req(ref_req),
        .ref_urgent(ref_urgent), .ref_busy(ref_busy));

    function automatic int f_cap();
        int c = int'(cfg[26:24]);
        return (c == 0) ? 1 : c;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // behavioural reference model, updated on each edge
    always @(posedge clk) begin
        int iv, rv, cp;
        bit tk, is;
        iv = int'(cfg[15:0]);
        rv = int'(cfg[23:16]);
        cp = f_cap();
        if (!rst_n || !init_done) begin
            m_intv = 0; m_pend = 0; m_busy = 0;
        end else begin
            tk = (m_intv >= iv + 1);
            is = (m_pend > 0) && (m_busy == 0) && ref_grant;
            m_intv = tk ? 0 : m_intv + 1;
            m_pend = m_pend + int'(tk) - int'(is);
            if (m_pend > cp) m_pend = cp;
            m_busy = is ? rv + 2 : ((m_busy > 0) ? m_busy - 1 : 0);
        end
    end

    // per-cycle comparison away from the edge
    always @(negedge clk) begin
        bit e_req, e_busy, e_urg;
        #1;
        cyc++;
        e_req  = init_done && (m_pend > 0) && (m_busy == 0);
        e_busy = init_done && (m_busy > 0);
        e_urg  = init_done && (m_pend == f_cap());
        chk(ref_req    == e_req,  "R4 ref_req",    int'(ref_req),    int'(e_req));
        chk(ref_busy   == e_busy, "R5 ref_busy",   int'(ref_busy),   int'(e_busy));
        chk(ref_urgent == e_urg,  "R7 ref_urgent", int'(ref_urgent), int'(e_urg));
        if (ref_req && ref_grant) issues.push_back(cyc);
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input logic [31:0] c);
        @(negedge clk);
        rst_n = 1'b0; init_done = 1'b0; ref_grant = 1'b0; cfg = c;
        wait_cyc(3);
        rst_n = 1'b1;
    endtask

    initial begin
        // phase A: I=10, R=3, C=4
        do_reset({5'b0, 3'd4, 8'd3, 16'd10});
        #2;
        chk(!ref_req && !ref_busy && !ref_urgent, "R9 reset outputs",
            int'({ref_req, ref_busy, ref_urgent}), 0);
        @(negedge clk);
        ref_grant = 1'b1;
        wait_cyc(20);
        #2;
        chk(!ref_req && !ref_busy, "R3 init low", int'({ref_req, ref_busy}), 0);
        chk(issues.size() == 0, "R8 grant ignored", issues.size(), 0);
        @(negedge clk);
        ref_grant = 1'b0;
        init_done = 1'b1;
        wait_cyc(11);
        #2;
        chk(!ref_req, "R2 before first expiry", int'(ref_req), 0);
        @(negedge clk);
        #2;
        chk(ref_req, "R2 first expiry at I+2", int'(ref_req), 1);
        wait_cyc(60);
        #2;
        chk(ref_urgent, "R7 urgent at cap", int'(ref_urgent), 1);
        @(negedge clk);
        issues.delete();
        ref_grant = 1'b1;
        wait_cyc(20);
        #2;
        chk(issues.size() >= 3, "R5 back-to-back count", issues.size(), 3);
        if (issues.size() >= 3) begin
            chk(issues[1] - issues[0] == 6, "R5 gap R+3", issues[1] - issues[0], 6);
            chk(issues[2] - issues[1] == 6, "R5 gap R+3", issues[2] - issues[1], 6);
        end
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            ref_grant = (k % 3) != 0;
        end
        @(negedge clk);
        init_done = 1'b0;
        wait_cyc(5);
        #2;
        chk(!ref_req && !ref_busy && !ref_urgent, "R3 init dropped",
            int'({ref_req, ref_busy, ref_urgent}), 0);

        // phase B: realistic fields, high bits set
        do_reset({5'b11111, 3'd7, 8'd24, 16'd1558});
        init_done = 1'b1;
        wait_cyc(14100);
        #2;
        chk(ref_urgent, "R7 urgent after long postponement", int'(ref_urgent), 1);
        @(negedge clk);
        issues.delete();
        ref_grant = 1'b1;
        wait_cyc(400);
        #2;
        chk(issues.size() == 7, "R6 capped backlog drained", issues.size(), 7);
        if (issues.size() >= 2)
            chk(issues[1] - issues[0] == 27, "R1 recovery field decode",
                issues[1] - issues[0], 27);

        // phase C: cap field zero acts as one
        do_reset({5'b0, 3'd0, 8'd1, 16'd5});
        init_done = 1'b1;
        wait_cyc(30);
        #2;
        chk(ref_urgent && ref_req, "R6 cap zero treated as one",
            int'({ref_urgent, ref_req}), 3);
        @(negedge clk);
        issues.delete();
        ref_grant = 1'b1;
        wait_cyc(2);
        #2;
        chk(issues.size() == 1 && ref_busy, "R4 single issue",
            issues.size(), 1);
        wait_cyc(10);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule